// File: doc/BRIEF.md
# Mode-Switched Receive Queue

This block holds received bytes for a 16550-style serial port until the register-read logic collects them. The line receiver, or the loopback path, offers bytes on a push port. The read side takes the oldest byte from a pop port. The queue runs in one of two modes. In character mode it holds a single byte. In FIFO mode it holds sixteen bytes. A level control input selects the mode.

A small controller tracks the mode as two named states: `MODE_CHAR`, the state out of reset, and `MODE_FIFO`. It has four transitions:
- **ENABLE** goes from `MODE_CHAR` to `MODE_FIFO` when the mode input rises.
- **DISABLE** goes from `MODE_FIFO` to `MODE_CHAR` when the mode input falls.
- **RESTART** is a self-loop in `MODE_FIFO`, taken when a receive reset arrives while the mode input is high.
- **HOLD** is a self-loop in either state when neither of the above applies.

ENABLE, DISABLE and RESTART each flush the storage in the same cycle. The new capacity applies from the next cycle.

The storage keeps its own read and write pointers, which wrap at the current capacity, and a separate occupancy counter. It reports the count, an empty flag and a full flag. When a push is refused, it raises a one-cycle rejection so that the caller can record an overrun.

Top module: `rx_depth_queue`

## Requirements
- R1: After reset the queue is in character mode: count 0, empty high, full low, and the head output reads 0xFF. A single accepted push then raises full.
- R2: In character mode the capacity is one byte. The count never exceeds 1, and a byte held there stays readable until it is popped.
- R3: In FIFO mode the capacity is sixteen bytes. They are returned oldest first, and full rises when the count reaches 16.
- R4: A push while full, with no accepted pop in the same cycle, raises `overrun` in that cycle. The count and the stored bytes are left unchanged.
- R5: While empty, `pop_data` reads 0xFF. A pop while empty leaves the count at 0.
- R6: Any change of `fifo_en` flushes the queue in that cycle. From the next cycle the capacity is 16 if `fifo_en` is 1 and 1 if it is 0.
- R7: `rx_reset` high while `fifo_en` is 1 flushes the queue and keeps the capacity at 16. While `fifo_en` stays 0, `rx_reset` has no effect on the contents.
- R8: A push and a pop in the same cycle on a non-empty queue, full or not, leave the count unchanged and do not raise `overrun`.
- R9: A flush overrides any push or pop in the same cycle: the next cycle shows count 0 and `overrun` stays low.
- R10: `pop_data` shows the oldest stored byte combinationally. A pop advances to the next byte at the clock edge.
- R11: `full` is high exactly when the count equals the current capacity. `empty` is high exactly when the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | Mode level: 1 selects the 16-byte mode, 0 selects the 1-byte mode |
| rx_reset | input | 1 | Receive-queue reset command; acts only while `fifo_en` is 1 |
| push | input | 1 | Offer `push_data` to the queue |
| push_data | input | 8 | Byte offered |
| pop | input | 1 | Consume the head byte |
| pop_data | output | 8 | Head byte, or 0xFF when empty |
| count | output | 5 | Bytes currently stored |
| empty | output | 1 | Count is zero |
| full | output | 1 | Count equals the current capacity |
| overrun | output | 1 | The push in this cycle is refused |

## Verification
The assertions take for granted that `push`, `pop`, `fifo_en` and `rx_reset` are known, clean levels sampled at the clock edge. They also assume that no caller relies on a pop from an empty queue having a side effect. The stimulus drives every input on the falling edge, so each value is stable across the following rising edge. Mode flips and receive resets are drawn rarely, so that the queue spends long stretches both full and in each mode. Pushes and pops are drawn independently, so pushes while full, pops while empty and simultaneous pairs all occur.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic {
        MODE_CHAR = 1'b0,
        MODE_FIFO = 1'b1
    } rxq_mode_e;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DEEP    = 16,
    parameter int SHALLOW = 1,
    parameter int CNT_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             rx_reset,
    output logic             flush,
    output logic [CNT_W-1:0] depth
);
    rxq_mode_e state, state_nx;

    // Next mode follows the level input.
    assign state_nx = fifo_en ? MODE_FIFO : MODE_CHAR;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= MODE_CHAR;
        else        state <= state_nx;
    end

    always_comb begin
        flush = 1'b0;
        depth = CNT_W'(SHALLOW);
        unique case (state)
            MODE_CHAR: begin
                depth = CNT_W'(SHALLOW);
                flush = fifo_en;                 // ENABLE
            end
            MODE_FIFO: begin
                depth = CNT_W'(DEEP);
                flush = !fifo_en || rx_reset;    // DISABLE or RESTART
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int          DATA_W    = 8,
    parameter int          DEEP      = 16,
    parameter int          CNT_W     = 5,
    parameter int          PTR_W     = 4,
    parameter logic [DATA_W-1:0] EMPTY_VAL = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [CNT_W-1:0]  depth,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic [CNT_W-1:0]  count,
    output logic              empty,
    output logic              full,
    output logic              overrun
);
    logic [DATA_W-1:0] mem [DEEP];
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic [CNT_W-1:0]  cnt;
    logic              do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p,
                                              input logic [CNT_W-1:0] lim);
        logic [CNT_W-1:0] n;
        n = CNT_W'(p) + CNT_W'(1);
        return (n >= lim) ? '0 : p + PTR_W'(1);
    endfunction

    assign empty    = (cnt == '0);
    assign full     = (cnt == depth);
    assign do_pop   = pop && !empty && !flush;
    assign do_push  = push && !flush && (!full || do_pop);
    assign overrun  = push && !flush && full && !do_pop;
    assign pop_data = empty ? EMPTY_VAL : mem[rd_ptr];
    assign count    = cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_pop)  rd_ptr <= step(rd_ptr, depth);
            if (do_push) wr_ptr <= step(wr_ptr, depth);
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + CNT_W'(1);
                2'b01:   cnt <= cnt - CNT_W'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // R3: occupancy never passes the active capacity
    p_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= depth);

    // R4: a refused push leaves the occupancy alone
    p_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> (count == $past(count)));

    // R5: popping an empty queue does nothing
    p_pop_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !flush) |=> (count == '0));

    // R8: paired push and pop keep the occupancy
    p_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !empty && !flush) |=> (count == $past(count)));

    // R9: flush wins over any same-cycle traffic
    p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));
endmodule

// File: rtl/rx_depth_queue.sv
module rx_depth_queue #(
    parameter int DATA_W  = 8,
    parameter int DEEP    = 16,
    parameter int SHALLOW = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              rx_reset,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic [$clog2(DEEP+1)-1:0] count,
    output logic              empty,
    output logic              full,
    output logic              overrun
);
    localparam int CNT_W = $clog2(DEEP + 1);
    localparam int PTR_W = (DEEP > 1) ? $clog2(DEEP) : 1;

    logic             flush;
    logic [CNT_W-1:0] depth;

    rxq_ctrl #(.DEEP(DEEP), .SHALLOW(SHALLOW), .CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_en  (fifo_en),
        .rx_reset (rx_reset),
        .flush    (flush),
        .depth    (depth)
    );

    rxq_store #(.DATA_W(DATA_W), .DEEP(DEEP), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .depth     (depth),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .pop_data  (pop_data),
        .count     (count),
        .empty     (empty),
        .full      (full),
        .overrun   (overrun)
    );

    // R2: in the single-byte mode the occupancy stays at most one
    p_char_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (depth == CNT_W'(SHALLOW)) |-> (count <= CNT_W'(SHALLOW)));
endmodule

// File: tb/sim_rx_depth_queue.sv
module sim_rx_depth_queue;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       fifo_en, rx_reset, push, pop;
    logic [7:0] push_data, pop_data;
    logic [4:0] count;
    logic       empty, full, overrun;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] mq[$];
    int   mdepth;
    bit   men_q;
    bit   cur_en;

    always #5 clk = ~clk;

    rx_depth_queue u0 (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_reset(rx_reset),
        .push(push), .push_data(push_data), .pop(pop), .pop_data(pop_data),
        .count(count), .empty(empty), .full(full), .overrun(overrun)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_head();
        return (mq.size() > 0) ? int'(mq[0]) : 255;
    endfunction

    // One clock: drive on the falling edge, compare before the rising edge, update the model.
    task automatic cycle(input bit en, input bit rr, input bit pu, input logic [7:0] d,
                         input bit po, input string tag);
        bit fl, popped, ov;
        int sz;
        @(negedge clk);
        fifo_en = en; rx_reset = rr; push = pu; push_data = d; pop = po;
        cur_en = en;
        #1;
        sz     = mq.size();
        fl     = (en != men_q) || (rr && en);
        popped = po && sz > 0 && !fl;
        ov     = pu && !fl && sz == mdepth && !popped;
        chk(tag, "count R11", int'(count), sz);
        chk(tag, "empty R11", int'(empty), int'(sz == 0));
        chk(tag, "full R11",  int'(full),  int'(sz == mdepth));
        chk(tag, "pop_data R10", int'(pop_data), exp_head());
        chk(tag, "overrun R4", int'(ov), int'(overrun));
        if (fl) begin
            mq.delete();
            mdepth = en ? 16 : 1;
        end else begin
            if (popped) void'(mq.pop_front());
            if (pu && (sz < mdepth || popped)) mq.push_back(d);
        end
        men_q = en;
    endtask

    task automatic idle(input string tag);
        cycle(cur_en, 1'b0, 1'b0, 8'h00, 1'b0, tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=timeout expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; fifo_en = 1'b0; rx_reset = 1'b0; push = 1'b0; pop = 1'b0;
        push_data = 8'h00; cur_en = 1'b0;
        mdepth = 1; men_q = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, then one byte fills character mode
        idle("R1");
        cycle(0, 0, 1, 8'hA5, 0, "R1");
        idle("R1");
        chk("R1", "full after one push", int'(full), 1);

        // R2: a second byte is refused, the held byte survives
        cycle(0, 0, 1, 8'h3C, 0, "R2");
        idle("R2");
        chk("R2", "held byte", int'(pop_data), 8'hA5);
        // R7: receive reset in character mode is ignored
        cycle(0, 1, 0, 8'h00, 0, "R7");
        idle("R7");
        chk("R7", "count kept", int'(count), 1);
        chk("R7", "byte kept", int'(pop_data), 8'hA5);

        // R6: enabling the FIFO flushes the held byte
        cycle(1, 0, 0, 8'h00, 0, "R6");
        idle("R6");
        chk("R6", "count after enable", int'(count), 0);

        // R3: sixteen bytes in order, then full
        for (int i = 0; i < 16; i++) cycle(1, 0, 1, 8'(8'h10 + i), 0, "R3");
        idle("R3");
        chk("R3", "full at sixteen", int'(full), 1);
        // R4: refused push while full
        cycle(1, 0, 1, 8'hEE, 0, "R4");
        // R8: pair at full keeps the count
        cycle(1, 0, 1, 8'h77, 1, "R8");
        idle("R8");
        chk("R8", "count after pair", int'(count), 16);
        for (int i = 0; i < 16; i++) cycle(1, 0, 0, 8'h00, 1, "R3");
        // R5: pop while empty
        cycle(1, 0, 0, 8'h00, 1, "R5");
        idle("R5");
        chk("R5", "empty head", int'(pop_data), 8'hFF);

        // R7: receive reset in FIFO mode flushes and keeps sixteen
        for (int i = 0; i < 3; i++) cycle(1, 0, 1, 8'(8'h40 + i), 0, "R7");
        cycle(1, 1, 0, 8'h00, 0, "R7");
        idle("R7");
        chk("R7", "count after restart", int'(count), 0);
        for (int i = 0; i < 16; i++) cycle(1, 0, 1, 8'(8'h50 + i), 0, "R7");
        idle("R7");
        chk("R7", "depth stays sixteen", int'(count), 16);

        // R9: flush overrides push and pop in the same cycle
        cycle(1, 1, 1, 8'h99, 1, "R9");
        idle("R9");
        chk("R9", "count after flush", int'(count), 0);

        // R6: disabling flushes and returns to one byte
        cycle(1, 0, 1, 8'h21, 0, "R6");
        cycle(0, 0, 0, 8'h00, 0, "R6");
        idle("R6");
        chk("R6", "count after disable", int'(count), 0);
        cycle(0, 0, 1, 8'h22, 0, "R6");
        cycle(0, 0, 1, 8'h23, 0, "R6");

        // Random mix checked against the model
        for (int n = 0; n < 4000; n++) begin
            bit en, rr, pu, po;
            en = cur_en;
            if (($urandom % 64) == 0) en = !cur_en;
            rr = (($urandom % 64) == 0);
            pu = (($urandom % 100) < 55);
            po = (($urandom % 100) < 40);
            cycle(en, rr, pu, 8'($urandom), po, "R3");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule